// File: doc/BRIEF.md
# Self-Triggered Strip Projection Readout

This block reads a binary pixel matrix with no external trigger. The matrix gives it one wired-OR line for every column and one for every row: a firing pixel pulls the line of its column and the line of its row. While the block is idle, any raised line starts a frame. In that cycle the block copies both sets of lines into two projection masks. It then pulses a clear strobe for one cycle so the matrix can reset its pixels and collect new hits while the frame is read out.

The readout sends only the set positions. A lowest-first priority search picks one column address per clock and then one row address per clock. Each address goes out on a valid/ready stream as a word with an axis tag, the address, a frame-end flag and a truncation flag. The result looks like the output of two crossed strip layers: it carries no per-pixel coordinates, and any ghost combinations are left to the consumer.

Every frame has a time budget counted in clock cycles. Stalled cycles also count against it. If addresses are still waiting when the budget is used up, the frame closes with a truncation word. The default budget of 400 cycles gives a 2 µs frame at 200 MHz.

Top module: `xy_proj_readout`

## Requirements
- R1: During and directly after reset, `out_valid_o` and `pix_clear_o` are low.
- R2: In the idle state, any high bit on `col_hit_i` or `row_hit_i` starts a frame, and `pix_clear_o` is high for exactly one cycle.
- R3: While all lines are low, no frame starts: `out_valid_o` and `pix_clear_o` stay low.
- R4: Column addresses come first in a frame, in ascending order, with `out_axis_o` = 0.
- R5: Row addresses follow all column addresses, in ascending order, with `out_axis_o` = 1.
- R6: `out_last_o` is 1 on the final word of each frame and 0 on every other word.
- R7: With `out_ready_i` held high, a frame's words come out on consecutive cycles with no gap.
- R8: While `out_valid_o` is high and `out_ready_i` is low, the output word and its valid stay unchanged.
- R9: A frame carries at most BUDGET address words. If addresses remain once BUDGET scan cycles have passed, the frame ends with one truncation word: `out_trunc_o` = 1, `out_last_o` = 1, `out_axis_o` = 0, address 0.
- R10: Line activity during a frame has no effect on that frame. Lines still high when the frame ends start the next frame.
- R11: A frame whose address count equals BUDGET ends on its last address word, with no truncation word.
- R12: A frame with no column bits set sends only row words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| col_hit_i | input | NCOL | Column OR lines from the matrix |
| row_hit_i | input | NROW | Row OR lines from the matrix |
| pix_clear_o | output | 1 | One-cycle strobe telling the matrix to clear its pixels |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Consumer accepts the word |
| out_axis_o | output | 1 | 0 = column address, 1 = row address |
| out_addr_o | output | ADDR_W | Column or row address |
| out_last_o | output | 1 | Final word of the frame |
| out_trunc_o | output | 1 | Truncation word |

## Verification
The bench builds the block with 32 columns, 24 rows and a budget of 10 cycles. With these values a frame of about a dozen hits overruns the budget, and another lands exactly on it, so both endings of R9 and R11 are tested with short masks. The narrow matrix still uses both the top and bottom address bits. The small budget also makes it possible to inject new line activity in the middle of a frame and check that the next frame starts afterwards.

// File: rtl/xy_proj_pkg.sv
package xy_proj_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_SCAN = 1'b1} rdo_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lowest_set.sv
module lowest_set #(
  parameter int W  = 256,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/proj_latch.sv
module proj_latch #(
  parameter int W  = 256,
  parameter int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [W-1:0]  load_vec,
  input  logic          drop,
  input  logic [IW-1:0] drop_idx,
  output logic [W-1:0]  mask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
    end else if (load) begin
      mask <= load_vec;
    end else if (drop) begin
      mask[drop_idx] <= 1'b0;
    end
  end
endmodule

// File: rtl/frame_timer.sv
module frame_timer #(
  parameter int BUDGET = 400,
  parameter int TW     = $clog2(BUDGET + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt != TW'(BUDGET)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = (cnt == TW'(BUDGET));
endmodule

// File: rtl/xy_proj_readout.sv
module xy_proj_readout
  import xy_proj_pkg::*;
#(
  parameter int NCOL   = 256,
  parameter int NROW   = 256,
  parameter int BUDGET = 400,
  parameter int ADDR_W = $clog2(imax(NCOL, NROW))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCOL-1:0]   col_hit_i,
  input  logic [NROW-1:0]   row_hit_i,
  output logic              pix_clear_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_axis_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic              out_last_o,
  output logic              out_trunc_o
);
  localparam int XIW = $clog2(NCOL);
  localparam int YIW = $clog2(NROW);

  rdo_state_t      state;
  logic [NCOL-1:0] xmask;
  logic [NROW-1:0] ymask;
  logic            x_found, y_found;
  logic [XIW-1:0]  x_idx;
  logic [YIW-1:0]  y_idx;
  logic            capture, advance, emit, pending, expired;
  logic            use_x, remaining, take_addr;
  logic [NCOL-1:0] x_rest;
  logic [NROW-1:0] y_rest;

  assign capture = (state == ST_IDLE) && ((|col_hit_i) || (|row_hit_i));
  assign advance = !out_valid_o || out_ready_i;
  assign emit    = (state == ST_SCAN) && advance;
  assign pending = x_found || y_found;
  assign use_x   = x_found;
  assign x_rest  = xmask & (xmask - 1'b1);
  assign y_rest  = ymask & (ymask - 1'b1);
  assign remaining = use_x ? ((|x_rest) || y_found) : (|y_rest);
  assign take_addr = emit && pending && !expired;

  proj_latch #(.W(NCOL), .IW(XIW)) u_xlatch (
    .clk(clk), .rst(rst), .load(capture), .load_vec(col_hit_i),
    .drop(take_addr && use_x), .drop_idx(x_idx), .mask(xmask)
  );

  proj_latch #(.W(NROW), .IW(YIW)) u_ylatch (
    .clk(clk), .rst(rst), .load(capture), .load_vec(row_hit_i),
    .drop(take_addr && !use_x), .drop_idx(y_idx), .mask(ymask)
  );

  lowest_set #(.W(NCOL), .IW(XIW)) u_xpick (
    .vec(xmask), .found(x_found), .idx(x_idx)
  );

  lowest_set #(.W(NROW), .IW(YIW)) u_ypick (
    .vec(ymask), .found(y_found), .idx(y_idx)
  );

  frame_timer #(.BUDGET(BUDGET)) u_timer (
    .clk(clk), .rst(rst), .run(state == ST_SCAN), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      pix_clear_o <= 1'b0;
      out_valid_o <= 1'b0;
      out_axis_o  <= 1'b0;
      out_addr_o  <= '0;
      out_last_o  <= 1'b0;
      out_trunc_o <= 1'b0;
    end else begin
      pix_clear_o <= capture;
      if (out_ready_i) begin
        out_valid_o <= 1'b0;
      end
      case (state)
        ST_IDLE: begin
          if (capture) begin
            state <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (emit) begin
            if (pending && expired) begin
              out_valid_o <= 1'b1;
              out_trunc_o <= 1'b1;
              out_last_o  <= 1'b1;
              out_axis_o  <= 1'b0;
              out_addr_o  <= '0;
              state       <= ST_IDLE;
            end else if (pending) begin
              out_valid_o <= 1'b1;
              out_trunc_o <= 1'b0;
              out_last_o  <= !remaining;
              out_axis_o  <= !use_x;
              out_addr_o  <= use_x ? ADDR_W'(x_idx) : ADDR_W'(y_idx);
              if (!remaining) begin
                state <= ST_IDLE;
              end
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xy_proj_checker.sv
module xy_proj_checker #(
  parameter int BUDGET = 400
) (
  input logic clk,
  input logic rst,
  input logic pix_clear_o,
  input logic out_valid_o,
  input logic out_ready_i,
  input logic out_axis_o,
  input logic out_last_o,
  input logic out_trunc_o,
  input logic [31:0] word_bits
);
  int   words_cnt;
  logic seen_y;

  always_ff @(posedge clk) begin
    if (rst) begin
      words_cnt <= 0;
      seen_y    <= 1'b0;
    end else if (out_valid_o && out_ready_i) begin
      if (out_last_o) begin
        words_cnt <= 0;
        seen_y    <= 1'b0;
      end else begin
        words_cnt <= words_cnt + 1;
        seen_y    <= seen_y | out_axis_o;
      end
    end
  end

  AST_CLEAR_PULSE: assert property (@(posedge clk) disable iff (rst)
    pix_clear_o |=> !pix_clear_o); // R2
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(word_bits))); // R8
  AST_TRUNC_LAST: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && out_trunc_o) |-> out_last_o); // R9
  AST_NO_EXCESS: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !out_trunc_o) |-> (words_cnt < BUDGET)); // R9
  AST_ROWS_AFTER_COLS: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !out_trunc_o && seen_y) |-> out_axis_o); // R5
endmodule

bind xy_proj_readout xy_proj_checker #(.BUDGET(BUDGET)) u_chk (
  .clk(clk), .rst(rst), .pix_clear_o(pix_clear_o),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .out_axis_o(out_axis_o), .out_last_o(out_last_o), .out_trunc_o(out_trunc_o),
  .word_bits(32'({out_trunc_o, out_last_o, out_axis_o, out_addr_o}))
);

// File: tb/xy_proj_readout_tb.sv
module xy_proj_readout_tb;
  localparam int NCOL   = 32;
  localparam int NROW   = 24;
  localparam int BUDGET = 10;
  localparam int ADDR_W = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NCOL-1:0]   col_hit = '0;
  logic [NROW-1:0]   row_hit = '0;
  logic              out_ready = 1'b1;
  logic              pix_clear, out_valid, out_axis, out_last, out_trunc;
  logic [ADDR_W-1:0] out_addr;

  int errors = 0;
  int checks = 0;
  int exp_q[$];
  int got_q[$];

  always #4 clk = ~clk;

  xy_proj_readout #(.NCOL(NCOL), .NROW(NROW), .BUDGET(BUDGET), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .col_hit_i(col_hit), .row_hit_i(row_hit),
    .pix_clear_o(pix_clear), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_axis_o(out_axis), .out_addr_o(out_addr), .out_last_o(out_last),
    .out_trunc_o(out_trunc)
  );

  function automatic int code(input int t, input int l, input int a, input int adr);
    return t * 1024 + l * 512 + a * 256 + adr;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // expected words from the requirements: X ascending (R4), Y ascending (R5), budget (R9)
  task automatic build_exp(input logic [NCOL-1:0] c, input logic [NROW-1:0] r);
    int n = 0;
    int total = 0;
    exp_q.delete();
    for (int i = 0; i < NCOL; i++) if (c[i]) total++;
    for (int i = 0; i < NROW; i++) if (r[i]) total++;
    for (int i = 0; i < NCOL; i++)
      if (c[i] && n < BUDGET) begin exp_q.push_back(code(0, 0, 0, i)); n++; end
    for (int i = 0; i < NROW; i++)
      if (r[i] && n < BUDGET) begin exp_q.push_back(code(0, 0, 1, i)); n++; end
    if (total > BUDGET) exp_q.push_back(code(1, 1, 0, 0));
    else exp_q[exp_q.size() - 1] = exp_q[exp_q.size() - 1] + 512;
  endtask

  task automatic wait_capture(input string tag);
    bit seen = 0;
    for (int k = 0; k < 10 && !seen; k++) begin
      @(negedge clk);
      if (pix_clear) seen = 1;
    end
    chk(seen, "R2", {tag, " clear strobe seen"}, seen, 1);
    col_hit = '0;
    row_hit = '0;
  endtask

  task automatic collect(input bit stall, input bit inj, input logic [NCOL-1:0] ic,
                         input logic [NROW-1:0] ir, input string tag);
    int  gaps = 0;
    int  clr_seen = 0;
    int  stab_bad = 0;
    bit  started = 0;
    bit  held = 0;
    bit  done = 0;
    int  prevw = 0;
    int  cur;
    got_q.delete();
    for (int cyc = 0; cyc < 200 && !done; cyc++) begin
      @(negedge clk);
      if (inj && cyc == 1) begin col_hit = ic; row_hit = ir; end
      if (pix_clear) clr_seen++;
      cur = code(int'(out_trunc), int'(out_last), int'(out_axis), int'(out_addr));
      if (held && (!out_valid || cur != prevw)) stab_bad++;
      out_ready = stall ? (cyc % 2 == 1) : 1'b1;
      if (out_valid) begin
        started = 1;
        if (out_ready) begin
          got_q.push_back(cur);
          held = 0;
          if (out_last) done = 1;
        end else begin
          held = 1;
          prevw = cur;
        end
      end else if (started) begin
        gaps++;
      end
    end
    out_ready = 1'b1;
    chk(got_q.size() == exp_q.size(), "R6 R9", {tag, " word count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
      string req;
      if (exp_q[i] >= 1024) req = "R9";
      else if (exp_q[i] % 512 >= 256) req = "R5";
      else req = "R4";
      chk(got_q[i] == exp_q[i], req, {tag, " word"}, got_q[i], exp_q[i]);
    end
    chk(clr_seen == 0, "R2 R10", {tag, " no capture inside frame"}, clr_seen, 0);
    if (stall) chk(stab_bad == 0, "R8", {tag, " held word stable"}, stab_bad, 0);
    else chk(gaps == 0, "R7", {tag, " gapless words"}, gaps, 0);
  endtask

  task automatic run_frame(input logic [NCOL-1:0] c, input logic [NROW-1:0] r,
                           input bit stall, input string tag);
    build_exp(c, r);
    @(negedge clk);
    col_hit = c;
    row_hit = r;
    wait_capture(tag);
    collect(stall, 1'b0, '0, '0, tag);
  endtask

  task automatic t_reset();
    chk(!out_valid, "R1", "valid after reset", int'(out_valid), 0);
    chk(!pix_clear, "R1", "clear after reset", int'(pix_clear), 0);
  endtask

  task automatic t_idle();
    int act = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (out_valid || pix_clear) act++;
    end
    chk(act == 0, "R3", "no activity without hits", act, 0);
  endtask

  task automatic t_basic();
    logic [NCOL-1:0] c = '0;
    logic [NROW-1:0] r = '0;
    c[3] = 1; c[17] = 1; c[31] = 1;
    r[0] = 1; r[5] = 1; r[23] = 1;
    run_frame(c, r, 1'b0, "basic R4 R5 R6 R7");
  endtask

  task automatic t_rows_only();
    logic [NROW-1:0] r = '0;
    r[2] = 1; r[9] = 1;
    run_frame('0, r, 1'b0, "rows only R12");
  endtask

  task automatic t_stall();
    logic [NCOL-1:0] c = '0;
    logic [NROW-1:0] r = '0;
    c[1] = 1; c[30] = 1; r[4] = 1; r[11] = 1;
    run_frame(c, r, 1'b1, "backpressure R8");
  endtask

  task automatic t_trunc();
    run_frame(NCOL'(32'h0000_0FF0), NROW'(24'h00_1F00), 1'b0, "overrun R9");
  endtask

  task automatic t_exact();
    run_frame(NCOL'(32'h8000_001F), NROW'(24'h80_0007), 1'b0, "exact budget R11");
  endtask

  task automatic t_retrigger();
    logic [NCOL-1:0] ca = '0, cb = '0;
    logic [NROW-1:0] ra = '0, rb = '0;
    ca[2] = 1; ca[3] = 1; ra[7] = 1;
    cb[10] = 1; rb[1] = 1; rb[2] = 1;
    build_exp(ca, ra);
    @(negedge clk);
    col_hit = ca;
    row_hit = ra;
    wait_capture("retrigger A R10");
    collect(1'b0, 1'b1, cb, rb, "retrigger A R10");
    build_exp(cb, rb);
    wait_capture("retrigger B R10");
    collect(1'b0, 1'b0, '0, '0, "retrigger B R10");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_idle();
    t_basic();
    t_rows_only();
    t_stall();
    t_trunc();
    t_exact();
    t_retrigger();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule